// File: doc/BRIEF.md
# Stepped-Key Block Cipher Core

This block encrypts one 64-bit block under a 128-bit key. The schedule never expands the key. The state is treated as a 4x4 grid of 4-bit cells, and the rounds are grouped into steps of four. A key half is XORed into the state only at the start of each step. The low half and the high half take turns, and the low half goes first. After the last step, one more key addition closes the cipher.

The datapath computes one round per clock. A gate in the key path passes the selected half only on cycles that open a step, and drives zeros on all other cycles. The user pulses `start` with the plaintext and key applied. One load cycle follows, then one cycle per round, then one cycle for the final key addition. `done` then pulses for one cycle. The ciphertext stays on its port until the next accepted start. The step count, the step length and the style of the key gate are parameters.

Top module: `stepkey_cipher`

## Requirements
- R1: After reset, `done` is 0 and `ciphertext` is all zeros.
- R2: A `start` seen while the core is idle captures `plaintext` and `key` at that clock edge. This is the load cycle, and rounds begin at the following edge.
- R3: `done` goes high right after clock edge number NUM_STEPS*STEP_LEN+1, counting from the edge that accepted `start`. With the defaults this is edge 49.
- R4: A key half is added only on a round whose index is a multiple of STEP_LEN. The gate forces zero on every other round.
- R5: Step s adds the low half `key[63:0]` when s is even and the high half `key[127:64]` when s is odd. Step 0 uses the low half.
- R6: The final key addition after the last round uses the half chosen by the parity of NUM_STEPS. With 12 steps it is the low half, and with 3 steps it is the high half.
- R7: Each round applies four operations in order. (1) Constants are XORed into column 0, with rows 0 to 3 getting 8, 9, 2, 3. (2) A 6-bit constant rc is XORed into column 1, with rows 0 and 2 getting rc[5:3] and rows 1 and 3 getting rc[2:0]. rc starts at 0, and before each round it updates to {rc[4:0], NOT(rc[5] XOR rc[4])}. (3) Every cell passes through the 4-bit S-box C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2, and then row i rotates left by i cells. (4) Each column (x0..x3, top first) goes four times through the map x -> (x1, x2, x3, 4x0+x1+2x2+2x3). The arithmetic is in GF(2^4) modulo x^4+x+1.
- R8: `done` stays high for exactly one cycle. `ciphertext` then holds its value while the core is idle and no start arrives.
- R9: A `start` that arrives while an encryption is running is ignored. The running result is unchanged.
- R10: Cell (row r, column c) occupies bits [63-4(4r+c) -: 4] of a block. Cell (0,0) is the most significant nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an encryption (accepted only while idle) |
| plaintext | input | 64 | Block to encrypt, sampled with an accepted start |
| key | input | 128 | Cipher key, sampled with an accepted start |
| done | output | 1 | One-cycle pulse when the ciphertext is valid |
| ciphertext | output | 64 | Encrypted block, held until the next accepted start |

## Verification
The bench builds two instances side by side. The first uses the default 12 steps with the AND-style gate. The second uses 3 steps with the mux-style gate. The 3-step copy ends on an odd step, so its final addition takes the high key half. That covers the other branch of R6 and the other gate variant, and its latency boundary comes at edge 13 instead of 49. Both copies get the same stimulus, and every result is compared with a behavioural model of the cipher written inside the bench.

// File: rtl/stepkey_pkg.sv
package stepkey_pkg;

   function automatic logic [3:0] sbox4(input logic [3:0] x);
      logic [3:0] y;
      case (x)
         4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
         4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
         4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
         4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
      endcase
      return y;
   endfunction

   function automatic logic [3:0] gf_x2(input logic [3:0] a);
      return {a[2:0], 1'b0} ^ (a[3] ? 4'h3 : 4'h0);
   endfunction

   function automatic logic [3:0] gf_x4(input logic [3:0] a);
      return gf_x2(gf_x2(a));
   endfunction

   // four passes of the companion map (0 1 0 0 / 0 0 1 0 / 0 0 0 1 / 4 1 2 2)
   function automatic logic [15:0] mix_column(input logic [15:0] v);
      logic [15:0] t;
      logic [3:0]  nw;
      t = v;
      for (int i = 0; i < 4; i++) begin
         nw = gf_x4(t[15:12]) ^ t[11:8] ^ gf_x2(t[7:4]) ^ gf_x2(t[3:0]);
         t  = {t[11:0], nw};
      end
      return t;
   endfunction

   function automatic logic [5:0] rc_next(input logic [5:0] rc);
      return {rc[4:0], ~(rc[5] ^ rc[4])};
   endfunction

endpackage

// File: rtl/stepkey_round.sv
module stepkey_round #(
   parameter int         CELL_W   = 4,
   parameter int         GRID     = 4,
   parameter int         RC_W     = 6,
   parameter logic [7:0] SIZE_TAG = 8'h80
) (
   input  logic [CELL_W*GRID*GRID-1:0] din,
   input  logic [RC_W-1:0]             rc,
   output logic [CELL_W*GRID*GRID-1:0] dout
);
   import stepkey_pkg::*;

   localparam int BLK = CELL_W*GRID*GRID;

   if (CELL_W != 4) begin : g_bad_cell
      $error("stepkey_round: CELL_W must be 4");
   end
   if (GRID != 4) begin : g_bad_grid
      $error("stepkey_round: GRID must be 4");
   end
   if (RC_W != 6) begin : g_bad_rc
      $error("stepkey_round: RC_W must be 6");
   end

   logic [3:0] sb [GRID][GRID];
   logic [3:0] sr [GRID][GRID];

   for (genvar r = 0; r < GRID; r++) begin : g_row
      for (genvar c = 0; c < GRID; c++) begin : g_col
         logic [3:0] cin, cst;
         assign cin = din[BLK-1-(r*GRID+c)*CELL_W -: CELL_W];
         if (c == 0) begin : g_c0
            assign cst = ((r < 2) ? SIZE_TAG[7:4] : SIZE_TAG[3:0]) ^ 4'(r);
         end else if (c == 1) begin : g_c1
            assign cst = (r % 2 == 0) ? {1'b0, rc[5:3]} : {1'b0, rc[2:0]};
         end else begin : g_cx
            assign cst = 4'h0;
         end
         assign sb[r][c] = sbox4(cin ^ cst);
         assign sr[r][c] = sb[r][(c+r)%GRID];
      end
   end

   for (genvar c = 0; c < GRID; c++) begin : g_mix
      logic [15:0] mixed;
      assign mixed = mix_column({sr[0][c], sr[1][c], sr[2][c], sr[3][c]});
      for (genvar r = 0; r < GRID; r++) begin : g_out
         assign dout[BLK-1-(r*GRID+c)*CELL_W -: CELL_W] = mixed[15-r*4 -: 4];
      end
   end

endmodule

// File: rtl/stepkey_keygate.sv
module stepkey_keygate #(
   parameter int HALF_W = 64,
   parameter int STYLE  = 0   // 0: AND mask, 1: mux to zero
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                hi_sel,
   input  logic [2*HALF_W-1:0] key_q,
   output logic [HALF_W-1:0]   kout
);
   logic [HALF_W-1:0] half;
   assign half = hi_sel ? key_q[2*HALF_W-1:HALF_W] : key_q[HALF_W-1:0];

   if (STYLE == 0) begin : g_and
      assign kout = {HALF_W{en}} & half;
   end else if (STYLE == 1) begin : g_mux
      assign kout = en ? half : '0;
   end else begin : g_bad
      $error("stepkey_keygate: STYLE must be 0 or 1");
   end

   // R4
   key_gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (kout == '0));

endmodule

// File: rtl/stepkey_ctrl.sv
module stepkey_ctrl #(
   parameter int NUM_STEPS = 12,
   parameter int STEP_LEN  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       load,
   output logic       busy,
   output logic       round_en,
   output logic       key_en,
   output logic       hi_sel,
   output logic [5:0] rc,
   output logic       done
);
   import stepkey_pkg::*;

   localparam int ROUNDS   = NUM_STEPS * STEP_LEN;
   localparam int CW       = $clog2(ROUNDS + 1);
   localparam int LOG_STEP = $clog2(STEP_LEN);

   if (STEP_LEN < 2 || (1 << LOG_STEP) != STEP_LEN) begin : g_bad_step
      $error("stepkey_ctrl: STEP_LEN must be a power of two >= 2");
   end
   if (NUM_STEPS < 1) begin : g_bad_steps
      $error("stepkey_ctrl: NUM_STEPS must be >= 1");
   end

   logic [CW-1:0] cnt;
   logic          fin;

   assign fin      = (cnt == CW'(ROUNDS));
   assign load     = start && !busy;
   assign round_en = busy && !fin;
   assign key_en   = busy && (cnt[LOG_STEP-1:0] == '0);
   assign hi_sel   = cnt[LOG_STEP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         rc   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
            rc   <= rc_next(6'd0);
         end else if (busy) begin
            if (fin) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
               rc  <= rc_next(rc);
            end
         end
      end
   end

   // R3
   round_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));

   // R9
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !fin) |=> (cnt != '0));

endmodule

// File: rtl/stepkey_cipher.sv
module stepkey_cipher #(
   parameter int NUM_STEPS  = 12,
   parameter int STEP_LEN   = 4,
   parameter int GATE_STYLE = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [63:0]  plaintext,
   input  logic [127:0] key,
   output logic         done,
   output logic [63:0]  ciphertext
);
   logic [63:0]  state_q, keyed, rnd_out, kmask;
   logic [127:0] key_q;
   logic         load, busy, round_en, key_en, hi_sel;
   logic [5:0]   rc;

   stepkey_ctrl #(.NUM_STEPS(NUM_STEPS), .STEP_LEN(STEP_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .load(load), .busy(busy),
      .round_en(round_en), .key_en(key_en), .hi_sel(hi_sel), .rc(rc), .done(done)
   );

   stepkey_keygate #(.HALF_W(64), .STYLE(GATE_STYLE)) u_gate (
      .clk(clk), .rst_n(rst_n), .en(key_en), .hi_sel(hi_sel),
      .key_q(key_q), .kout(kmask)
   );

   assign keyed = state_q ^ kmask;

   stepkey_round #(.CELL_W(4), .GRID(4), .RC_W(6), .SIZE_TAG(8'h80)) u_round (
      .din(keyed), .rc(rc), .dout(rnd_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         key_q   <= '0;
      end else if (load) begin
         state_q <= plaintext;
         key_q   <= key;
      end else if (busy) begin
         state_q <= round_en ? rnd_out : keyed;
      end
   end

   assign ciphertext = state_q;

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (ciphertext == $past(plaintext)));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(ciphertext));

endmodule

// File: tb/tb_stepkey_cipher.sv
`timescale 1ns/1ps
module tb_stepkey_cipher;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [63:0]  pt = '0;
   logic [127:0] key = '0;
   logic         doneL, doneS;
   logic [63:0]  ctL, ctS;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   stepkey_cipher #(.NUM_STEPS(12), .STEP_LEN(4), .GATE_STYLE(0)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .plaintext(pt), .key(key),
      .done(doneL), .ciphertext(ctL));

   stepkey_cipher #(.NUM_STEPS(3), .STEP_LEN(4), .GATE_STYLE(1)) dut_s (
      .clk(clk), .rst_n(rst_n), .start(start), .plaintext(pt), .key(key),
      .done(doneS), .ciphertext(ctS));

   // ---------- reference model ----------
   localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                      4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
   localparam logic [3:0] COL0 [4] = '{4'h8, 4'h9, 4'h2, 4'h3};

   function automatic logic [3:0] gfm(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] p = 0, x = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) p ^= x;
         x = x[3] ? ({x[2:0], 1'b0} ^ 4'h3) : {x[2:0], 1'b0};
      end
      return p;
   endfunction

   function automatic logic [63:0] model(input logic [63:0] p, input logic [127:0] k, input int nsteps);
      logic [3:0] s [16];
      logic [3:0] t [16];
      logic [63:0] blk;
      logic [5:0] rc = 0;
      logic [3:0] col [4];
      logic [3:0] nv;
      blk = p;
      for (int st = 0; st < nsteps; st++) begin
         blk ^= (st % 2 == 0) ? k[63:0] : k[127:64];
         for (int i = 0; i < 16; i++) s[i] = blk[63-4*i -: 4];
         for (int j = 0; j < 4; j++) begin
            rc = {rc[4:0], ~(rc[5] ^ rc[4])};
            for (int r = 0; r < 4; r++) begin
               s[r*4]   ^= COL0[r];
               s[r*4+1] ^= (r % 2 == 0) ? {1'b0, rc[5:3]} : {1'b0, rc[2:0]};
            end
            for (int i = 0; i < 16; i++) s[i] = SB[s[i]];
            for (int r = 0; r < 4; r++)
               for (int c = 0; c < 4; c++) t[r*4+c] = s[r*4 + (c+r)%4];
            for (int c = 0; c < 4; c++) begin
               for (int r = 0; r < 4; r++) col[r] = t[r*4+c];
               for (int it = 0; it < 4; it++) begin
                  nv = gfm(col[0], 4'h4) ^ col[1] ^ gfm(col[2], 4'h2) ^ gfm(col[3], 4'h2);
                  col[0] = col[1]; col[1] = col[2]; col[2] = col[3]; col[3] = nv;
               end
               for (int r = 0; r < 4; r++) s[r*4+c] = col[r];
            end
         end
         for (int i = 0; i < 16; i++) blk[63-4*i -: 4] = s[i];
      end
      blk ^= (nsteps % 2 == 0) ? k[63:0] : k[127:64];
      return blk;
   endfunction

   // ---------- check helpers ----------
   task automatic check64(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // run one encryption on both instances; optionally poke start while busy
   task automatic encrypt(input logic [63:0] p, input logic [127:0] k, input int poke,
                          output int latL, output int latS,
                          output logic [63:0] rL, output logic [63:0] rS,
                          output bit pulseL, output bit pulseS,
                          output bit holdL, output bit holdS);
      latL = -1; latS = -1; rL = '0; rS = '0;
      pulseL = 0; pulseS = 0; holdL = 0; holdS = 0;
      @(negedge clk); pt = p; key = k; start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      for (int e = 1; e <= 60; e++) begin
         if (e == poke) begin pt = ~p; key = ~k; start = 1'b1; end
         @(posedge clk); @(negedge clk);
         start = 1'b0; pt = p; key = k;
         if (latL < 0 && doneL) begin latL = e; rL = ctL; end
         else if (latL >= 0 && e == latL + 1) pulseL = !doneL;
         else if (latL >= 0 && e == latL + 5) holdL = (ctL == rL);
         if (latS < 0 && doneS) begin latS = e; rS = ctS; end
         else if (latS >= 0 && e == latS + 1) pulseS = !doneS;
         else if (latS >= 0 && e == latS + 5) holdS = (ctS == rS);
      end
   endtask

   task automatic vector_pair(input logic [63:0] p, input logic [127:0] k, input string tag);
      int latL, latS;
      logic [63:0] rL, rS, eL, eS;
      bit pL, pS, hL, hS;
      eL = model(p, k, 12);
      eS = model(p, k, 3);
      encrypt(p, k, 0, latL, latS, rL, rS, pL, pS, hL, hS);
      check64(rL == eL, {"R7 12-step ", tag}, rL, eL);
      check64(rS == eS, {"R7 3-step ", tag}, rS, eS);
   endtask

   // ---------- scenarios ----------
   task automatic test_reset();
      check64(doneL == 1'b0 && ctL == '0, "R1 reset 12-step", {63'd0, doneL} | ctL, '0);
      check64(doneS == 1'b0 && ctS == '0, "R1 reset 3-step", {63'd0, doneS} | ctS, '0);
   endtask

   task automatic test_zero();
      int latL, latS;
      logic [63:0] rL, rS, eL, eS;
      bit pL, pS, hL, hS;
      eL = model('0, '0, 12);
      eS = model('0, '0, 3);
      encrypt('0, '0, 0, latL, latS, rL, rS, pL, pS, hL, hS);
      check64(rL == eL, "R7 zero 12-step", rL, eL);
      check64(rS == eS, "R7 zero 3-step", rS, eS);
      check64(latL == 49, "R3 latency 12-step", 64'(latL), 64'd49);
      check64(latS == 13, "R3 latency 3-step", 64'(latS), 64'd13);
      check64(pL && pS, "R8 done one-cycle pulse", {62'd0, pL, pS}, 64'd3);
      check64(hL && hS, "R8 ciphertext held", {62'd0, hL, hS}, 64'd3);
   endtask

   task automatic test_incr();
      vector_pair(64'h0123456789ABCDEF, 128'h0123456789ABCDEF_FEDCBA9876543210, "R2 incrementing");
      vector_pair(64'hFEDCBA9876543210, 128'h00112233445566778899AABBCCDDEEFF, "R2 back-to-back");
   endtask

   task automatic test_halves();
      // R5: only the low half nonzero, then only the high half nonzero
      vector_pair(64'h0, {64'h0, 64'hA5A5_0F0F_3C3C_9696}, "R5 low-only key");
      vector_pair(64'h0, {64'hA5A5_0F0F_3C3C_9696, 64'h0}, "R5 high-only key");
      // R6: 3-step copy ends on the high half
      vector_pair(64'h1111_2222_3333_4444, {64'hDEAD_BEEF_0000_0001, 64'h0}, "R6 final half parity");
   endtask

   task automatic test_keygate();
      // R4: a key of all ones would corrupt every round if the gate leaked
      vector_pair(64'h0, {128{1'b1}}, "R4 all-ones key");
      vector_pair(64'h8000_0000_0000_0001, 128'h5555_5555_5555_5555_AAAA_AAAA_AAAA_AAAA, "R4 alternating key");
   endtask

   task automatic test_busy_start();
      int latL, latS;
      logic [63:0] rL, rS, eL, eS;
      bit pL, pS, hL, hS;
      logic [63:0] p = 64'h0F1E_2D3C_4B5A_6978;
      logic [127:0] k = 128'h1357_9BDF_0246_8ACE_FDB9_7531_ECA8_6420;
      eL = model(p, k, 12);
      eS = model(p, k, 3);
      encrypt(p, k, 5, latL, latS, rL, rS, pL, pS, hL, hS);
      check64(rL == eL, "R9 start while busy 12-step", rL, eL);
      check64(rS == eS, "R9 start while busy 3-step", rS, eS);
      check64(latL == 49 && latS == 13, "R9 latency unchanged", {32'(latL), 32'(latS)}, {32'd49, 32'd13});
   endtask

   task automatic test_cells();
      vector_pair(64'hF000_0000_0000_0000, '0, "R10 cell (0,0)");
      vector_pair(64'h0000_0000_0000_000F, '0, "R10 cell (3,3)");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_zero();
      test_incr();
      test_halves();
      test_keygate();
      test_busy_start();
      test_cells();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule